// File: doc/BRIEF.md
# Debug Halt Entry Controller

This block decides when the processor leaves normal execution and sits in a halted debug state. There are two ways in. The first is the level of the external debug pin when reset is released. The second is a break opcode (value 0x00) reported by the CPU decode stage. Break entry is governed by a breakpoint-enable bit. When that bit is clear, the opcode is flagged back to the CPU as a plain no-op, and execution carries on.

While halted, the block holds a halt request towards the CPU. It accepts two commands from the debug command path. A resume command returns the CPU to normal running. An execute request releases a single-cycle go strobe, so that the CPU can carry out one instruction supplied by the host while it otherwise stays idle. The external pin passes through a synchronizer. It is looked at only once, on the first clock edge after reset is released.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While `rst_ni` is low, `dbg_mode_o`, `halt_o` and `exec_go_o` are all 0.
- R2: If the synchronized `dbg_pin_i` is low at the first rising clock edge after `rst_ni` goes high, `dbg_mode_o` is 1 after that edge.
- R3: If `dbg_pin_i` is high at that first edge, the block stays in run mode. Later changes of the pin have no effect until the next reset.
- R4: In run mode, `op_valid_i`=1 with `op_code_i`=8'h00 while breakpoints are enabled sets `dbg_mode_o` to 1 on the next edge.
- R5: With breakpoints disabled, a valid 8'h00 opcode drives `brk_nop_o` high in the same cycle and leaves the mode unchanged.
- R6: An opcode other than 8'h00, or any opcode with `op_valid_i`=0, never causes entry and never drives `brk_nop_o` high.
- R7: A break opcode arriving while already in debug mode has no further effect, and the block stays halted.
- R8: `resume_i` in debug mode clears `dbg_mode_o` on the next edge. In run mode it has no effect.
- R9: When `resume_i` and an enabled break opcode occur in the same cycle in debug mode, the resume wins and the block returns to run mode.
- R10: In debug mode, `exec_req_i` without `resume_i` produces a one-cycle `exec_go_o` pulse on the next edge. No two pulses are adjacent, `halt_o` stays high, and the request is ignored in run mode.
- R11: The breakpoint-enable bit resets to disabled. A write (`bpen_we_i`=1, value `bpen_d_i`) takes effect from the following edge.
- R12: `halt_o` equals `dbg_mode_o` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_pin_i | input | 1 | External debug pin level, asynchronous |
| op_valid_i | input | 1 | Decode stage presents an opcode this cycle |
| op_code_i | input | 8 | Opcode from the decode stage |
| bpen_we_i | input | 1 | Write strobe for the breakpoint-enable bit |
| bpen_d_i | input | 1 | New breakpoint-enable value |
| resume_i | input | 1 | Resume command from the debug command path |
| exec_req_i | input | 1 | Request to execute one host-supplied instruction |
| halt_o | output | 1 | Halt/idle request to the CPU |
| dbg_mode_o | output | 1 | Debug mode status |
| brk_nop_o | output | 1 | Current break opcode must execute as a no-op |
| exec_go_o | output | 1 | One-cycle strobe allowing one instruction to execute |

## Verification
Reset is applied once with the pin low and once with the pin high. This separates pin entry from a pin that only falls after the sampling edge. The break path is tried with the enable bit clear and set, with a non-zero opcode, and with 0x00 on the bus while the valid strobe is low. Only the enabled, valid 0x00 case may halt. Inside debug mode the pattern includes a repeated break, a held execute request that must give one pulse and then rest, and a resume together with a break in the same cycle, which shows the resume priority.

// File: rtl/dbgh_pkg.sv
package dbgh_pkg;
  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] BRK_OPCODE = '0;

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_HALT = 1'b1
  } mode_e;

  function automatic logic is_break_op(input logic valid, input logic [OP_W-1:0] op);
    return valid && (op == BRK_OPCODE);
  endfunction
endpackage

// File: rtl/dbgh_sync.sv
module dbgh_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk_i) s_q <= d_i;
      assign q_o = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i) chain_q <= {chain_q[STAGES-2:0], d_i};
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dbgh_entry_sample.sv
module dbgh_entry_sample (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_sync_i,
  output logic pin_entry_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b1;
    else         armed_q <= 1'b0;
  end

  assign pin_entry_o = armed_q & ~pin_sync_i;

  // R3
  armed_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !armed_q);

  // R3
  entry_only_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !pin_entry_o);
endmodule

// File: rtl/dbgh_brk_filter.sv
module dbgh_brk_filter
  import dbgh_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_code_i,
  input  logic            bpen_we_i,
  input  logic            bpen_d_i,
  output logic            brk_fire_o,
  output logic            brk_nop_o
);
  logic bpen_q;
  logic is_brk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bpen_q <= 1'b0;
    else if (bpen_we_i) bpen_q <= bpen_d_i;
  end

  assign is_brk     = is_break_op(op_valid_i, op_code_i);
  assign brk_fire_o = is_brk & bpen_q;
  assign brk_nop_o  = is_brk & ~bpen_q;

  // R5
  fire_nop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(brk_fire_o && brk_nop_o));

  // R11
  bpen_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bpen_we_i |=> (bpen_q == $past(bpen_d_i)));
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbgh_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dbg_pin_i,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_code_i,
  input  logic            bpen_we_i,
  input  logic            bpen_d_i,
  input  logic            resume_i,
  input  logic            exec_req_i,
  output logic            halt_o,
  output logic            dbg_mode_o,
  output logic            brk_nop_o,
  output logic            exec_go_o
);
  logic  pin_sync;
  logic  pin_entry;
  logic  brk_fire;
  logic  brk_nop;
  mode_e mode_q, mode_d;
  logic  exec_go_q;
  logic  exec_go_d;
  logic  in_halt;

  dbgh_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (dbg_pin_i),
    .q_o   (pin_sync)
  );

  dbgh_entry_sample u_entry (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_sync_i  (pin_sync),
    .pin_entry_o (pin_entry)
  );

  dbgh_brk_filter u_brk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_valid_i (op_valid_i),
    .op_code_i  (op_code_i),
    .bpen_we_i  (bpen_we_i),
    .bpen_d_i   (bpen_d_i),
    .brk_fire_o (brk_fire),
    .brk_nop_o  (brk_nop)
  );

  assign in_halt = (mode_q == MODE_HALT);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:  if (pin_entry || brk_fire) mode_d = MODE_HALT;
      MODE_HALT: if (resume_i)              mode_d = MODE_RUN;
      default:                              mode_d = MODE_RUN;
    endcase
  end

  assign exec_go_d = in_halt & ~resume_i & exec_req_i & ~exec_go_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_RUN;
      exec_go_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      exec_go_q <= exec_go_d;
    end
  end

  assign dbg_mode_o = in_halt;
  assign halt_o     = in_halt;
  assign brk_nop_o  = brk_nop;
  assign exec_go_o  = exec_go_q;

  // R2
  pin_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_entry |=> in_halt);

  // R4
  brk_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_halt && brk_fire) |=> in_halt);

  // R5
  nop_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_halt && brk_nop && !pin_entry) |=> !in_halt);

  // R7
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_halt && !resume_i) |=> in_halt);

  // R8
  resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_halt && resume_i) |=> !in_halt);

  // R10
  exec_in_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_go_q |-> in_halt);

  // R10
  exec_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_go_q |=> !exec_go_q);
endmodule

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] op_code = 8'hFF;
  logic       bpen_we = 1'b0;
  logic       bpen_d = 1'b0;
  logic       resume = 1'b0;
  logic       exec_req = 1'b0;
  logic       halt, dbg_mode, brk_nop, exec_go;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  dbg_halt_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .dbg_pin_i(pin),
    .op_valid_i(op_valid), .op_code_i(op_code),
    .bpen_we_i(bpen_we), .bpen_d_i(bpen_d),
    .resume_i(resume), .exec_req_i(exec_req),
    .halt_o(halt), .dbg_mode_o(dbg_mode),
    .brk_nop_o(brk_nop), .exec_go_o(exec_go)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // fields: we, d, valid, code[7:0], resume, exec, exp_dbg, exp_exec, exp_nop
  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}, // R5 R11 disabled after reset
    {1'b1,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0}, // R11 enable write
    {1'b0,1'b0,1'b1,8'h5A,1'b0,1'b0,1'b0,1'b0,1'b0}, // R6 other opcode
    {1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0}, // R6 not valid
    {1'b0,1'b0,1'b0,8'hFF,1'b0,1'b1,1'b0,1'b0,1'b0}, // R10 exec in run ignored
    {1'b0,1'b0,1'b0,8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0}, // R8 resume in run ignored
    {1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0}, // R4 enter
    {1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0}, // R7 break in halt
    {1'b0,1'b0,1'b0,8'hFF,1'b0,1'b1,1'b1,1'b1,1'b0}, // R10 pulse
    {1'b0,1'b0,1'b0,8'hFF,1'b0,1'b1,1'b1,1'b0,1'b0}, // R10 held, no adjacent pulse
    {1'b0,1'b0,1'b0,8'hFF,1'b0,1'b1,1'b1,1'b1,1'b0}, // R10 pulse again
    {1'b0,1'b0,1'b0,8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0}, // R8 resume
    {1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,1'b1,1'b0,1'b0}, // R4 enter again
    {1'b0,1'b0,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0}, // R9 resume wins
    {1'b1,1'b0,1'b0,8'hFF,1'b0,1'b0,1'b0,1'b0,1'b0}, // R11 disable write
    {1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,1'b1}  // R5 nop again
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // reset with pin low
    repeat (5) @(posedge clk);
    #1;
    chk("R1 dbg_mode in reset", dbg_mode, 1'b0);
    chk("R1 halt in reset", halt, 1'b0);
    chk("R1 exec_go in reset", exec_go, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R2 pin-low entry", dbg_mode, 1'b1);
    chk("R12 halt follows mode", halt, 1'b1);
    pin = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R2 pin rise ignored", dbg_mode, 1'b1);
    @(negedge clk); resume = 1'b1;
    @(posedge clk); #1;
    chk("R8 resume after pin entry", dbg_mode, 1'b0);
    @(negedge clk); resume = 1'b0;

    // reset with pin high
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R3 pin-high no entry", dbg_mode, 1'b0);
    @(negedge clk); pin = 1'b0;
    repeat (5) @(posedge clk); #1;
    chk("R3 late pin low ignored", dbg_mode, 1'b0);
    chk("R3 halt stays low", halt, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {bpen_we, bpen_d, op_valid, op_code, resume, exec_req} = VEC[i][15:3];
      #1;
      chk($sformatf("R5/R6 nop row %0d", i), brk_nop, VEC[i][0]);
      @(posedge clk); #1;
      chk($sformatf("R4/R7/R8/R9 mode row %0d", i), dbg_mode, VEC[i][2]);
      chk($sformatf("R12 halt row %0d", i), halt, VEC[i][2]);
      chk($sformatf("R10 exec row %0d", i), exec_go, VEC[i][1]);
    end
    @(negedge clk);
    {bpen_we, bpen_d, op_valid, op_code, resume, exec_req} = {1'b0,1'b0,1'b0,8'hFF,1'b0,1'b0};

    // reset while halted returns enable to disabled
    @(negedge clk); bpen_we = 1'b1; bpen_d = 1'b1;
    @(negedge clk); bpen_we = 1'b0; op_valid = 1'b1; op_code = 8'h00;
    @(posedge clk); #1;
    chk("R4 enter before reset", dbg_mode, 1'b1);
    @(negedge clk); op_valid = 1'b0; pin = 1'b1; rst_n = 1'b0;
    #1;
    chk("R1 async reset clears mode", dbg_mode, 1'b0);
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); op_valid = 1'b1; op_code = 8'h00;
    #1;
    chk("R11 enable reset to disabled", brk_nop, 1'b1);
    @(posedge clk); #1;
    chk("R11 no entry after reset", dbg_mode, 1'b0);
    @(negedge clk); op_valid = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule